// File: doc/BRIEF.md
# Per-Instruction Stride Data Prefetcher

This block watches the load and store stream of a core and learns, for each memory instruction, the distance between its successive data addresses. It keeps a direct-mapped table of learned patterns, indexed by the instruction address. When an instruction's pattern is trusted, the block predicts the next data address as the current address plus the learned stride. It then asks the L1 data cache whether that line is already present, and raises a prefetch request only when the line is missing.

Each table slot holds a tag, the last data address, a signed stride and a two-bit confidence state. A stride that repeats builds confidence. A stride that breaks lowers confidence or turns prediction off. A slot that later sees a regular pattern again can regain it. One access event is accepted per cycle. The tag probe goes out one cycle after the event is accepted, and the prefetch request follows in the cycle after that.

Top module: `stride_pf`

## Requirements
- R1: After reset, `probe_valid_o` and `pf_valid_o` are low, `acc_ready_o` is high, and every slot is empty (all tags are zero). The first access from any instruction therefore produces no probe.
- R2: The slot index is `acc_pc_i[PC_LSB +: log2(ENTRIES)]` (bits [5:2] by default). The tag is the PC bits above the index. A stored tag of zero means the slot is empty. An instruction that maps to the same slot with a different tag evicts the resident pattern.
- R3: When the tag does not match, or the slot is empty, the slot is written with the new tag, the access address as the last address, a stride of 0 and the state initial.
- R4: When the tag matches, the observed stride is the access address minus the stored last address, in two's complement at full address width, so negative strides are allowed. The last address then becomes the access address.
- R5: Repeated stride (observed equals stored). initial, transient and steady all go to steady, and no-prediction goes to transient. The stored stride is left unchanged.
- R6: Broken stride. initial goes to transient and transient goes to no-prediction; in both cases the stored stride takes the observed stride. steady goes to initial and keeps its stored stride. no-prediction stays in no-prediction and takes the observed stride.
- R7: After the update, a candidate is formed in the states initial (00), transient (01) and steady (10). The candidate target is the access address plus the stored stride, aligned down to a LINE_BYTES boundary. No candidate is formed in no-prediction (11).
- R8: No candidate is formed when the target line equals the line of the current access. This includes the stride of 0 that follows allocation.
- R9: A candidate accepted on clock edge N drives `probe_valid_o` with the line address in `probe_addr_o` during the cycle after edge N. `pf_valid_o` with that same address follows in the cycle after edge N+1, and only if `probe_hit_i` was low in the probe cycle.
- R10: Accesses on consecutive cycles from the same instruction each see the slot as updated by the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Memory access event present |
| acc_ready_o | output | 1 | Event accepted (always high) |
| acc_pc_i | input | AW | Instruction address of the load or store |
| acc_addr_i | input | AW | Effective data address |
| probe_valid_o | output | 1 | Tag probe request to the cache |
| probe_addr_o | output | AW | Line-aligned address being probed |
| probe_hit_i | input | 1 | Same-cycle response: line is present |
| pf_valid_o | output | 1 | Prefetch request |
| pf_addr_o | output | AW | Line-aligned prefetch address |

## Verification
The bench targets four groups of corner cases, each with a visible failure signature. The first is every row of the confidence transition table. A design that updates the stride when steady breaks would predict from the broken stride, not the old one. A design that keeps predicting in no-prediction would issue probes the bench does not expect. The second is negative strides, and strides small enough that the target stays inside the current line; a design that gets these wrong probes a wrong or redundant line. The third is aliasing between two instructions that share a slot, together with back-to-back accesses from one instruction; a stale read here misses the expected prefetch or issues an extra one. The fourth is the presence filter: a design that ignores the probe answer would issue a prefetch for a line the cache already holds. A long pseudo-random sweep over a small set of aliased instructions compares every probe and prefetch against an arithmetic model of the table.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;
  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_TRANS  = 2'd1,
    ST_STEADY = 2'd2,
    ST_NOPRED = 2'd3
  } conf_e;

  function automatic conf_e conf_next(conf_e cur, logic same);
    conf_e nxt;
    case (cur)
      ST_INIT:   nxt = same ? ST_STEADY : ST_TRANS;
      ST_TRANS:  nxt = same ? ST_STEADY : ST_NOPRED;
      ST_STEADY: nxt = same ? ST_STEADY : ST_INIT;
      default:   nxt = same ? ST_TRANS  : ST_NOPRED;
    endcase
    return nxt;
  endfunction

  // stride is replaced on a break, except when leaving steady
  function automatic logic take_stride(conf_e cur, logic same);
    return !same && (cur != ST_STEADY);
  endfunction
endpackage

// File: rtl/spf_table.sv
module spf_table #(
  parameter int ENTRIES = 16,
  parameter int AW      = 32,
  parameter int TAG_W   = 26,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic [AW-1:0]    rd_prev_o,
  output logic [AW-1:0]    rd_stride_o,
  output logic [1:0]       rd_state_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [AW-1:0]    wr_prev_i,
  input  logic [AW-1:0]    wr_stride_i,
  input  logic [1:0]       wr_state_i
);
  logic [TAG_W-1:0] tag_q    [ENTRIES];
  logic [AW-1:0]    prev_q   [ENTRIES];
  logic [AW-1:0]    stride_q [ENTRIES];
  logic [1:0]       state_q  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[g]    <= '0;
        prev_q[g]   <= '0;
        stride_q[g] <= '0;
        state_q[g]  <= 2'd0;
      end else if (sel) begin
        tag_q[g]    <= wr_tag_i;
        prev_q[g]   <= wr_prev_i;
        stride_q[g] <= wr_stride_i;
        state_q[g]  <= wr_state_i;
      end
    end
  end

  assign rd_tag_o    = tag_q[rd_idx_i];
  assign rd_prev_o   = prev_q[rd_idx_i];
  assign rd_stride_o = stride_q[rd_idx_i];
  assign rd_state_o  = state_q[rd_idx_i];
endmodule

// File: rtl/spf_update.sv
module spf_update
  import stride_pf_pkg::*;
#(
  parameter int AW         = 32,
  parameter int TAG_W      = 26,
  parameter int LINE_BYTES = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic [TAG_W-1:0] pc_tag_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [TAG_W-1:0] ent_tag_i,
  input  logic [AW-1:0]    ent_prev_i,
  input  logic [AW-1:0]    ent_stride_i,
  input  logic [1:0]       ent_state_i,
  output logic [TAG_W-1:0] new_tag_o,
  output logic [AW-1:0]    new_prev_o,
  output logic [AW-1:0]    new_stride_o,
  output logic [1:0]       new_state_o,
  output logic             cand_valid_o,
  output logic [AW-1:0]    cand_line_o
);
  localparam logic [AW-1:0] LINE_MASK = ~AW'(LINE_BYTES - 1);

  logic          hit, same;
  logic [AW-1:0] seen_stride, target;
  conf_e         cur, nxt;

  assign cur         = conf_e'(ent_state_i);
  assign hit         = (ent_tag_i == pc_tag_i) && (ent_tag_i != '0);
  assign seen_stride = addr_i - ent_prev_i;
  assign same        = (seen_stride == ent_stride_i);

  always_comb begin
    new_tag_o  = pc_tag_i;
    new_prev_o = addr_i;
    if (!hit) begin
      nxt          = ST_INIT;
      new_stride_o = '0;
    end else begin
      nxt          = conf_next(cur, same);
      new_stride_o = take_stride(cur, same) ? seen_stride : ent_stride_i;
    end
    new_state_o = nxt;
  end

  assign target       = addr_i + new_stride_o;
  assign cand_line_o  = target & LINE_MASK;
  assign cand_valid_o = (nxt != ST_NOPRED) && (cand_line_o != (addr_i & LINE_MASK));
endmodule

// File: rtl/spf_issue.sv
module spf_issue #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cand_valid_i,
  input  logic [AW-1:0] cand_line_i,
  output logic          probe_valid_o,
  output logic [AW-1:0] probe_addr_o,
  input  logic          probe_hit_i,
  output logic          pf_valid_o,
  output logic [AW-1:0] pf_addr_o
);
  logic          probe_q;
  logic [AW-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      probe_q    <= 1'b0;
      line_q     <= '0;
      pf_valid_o <= 1'b0;
      pf_addr_o  <= '0;
    end else begin
      probe_q    <= cand_valid_i;
      if (cand_valid_i) line_q <= cand_line_i;
      pf_valid_o <= probe_q && !probe_hit_i;
      if (probe_q) pf_addr_o <= line_q;
    end
  end

  assign probe_valid_o = probe_q;
  assign probe_addr_o  = line_q;
endmodule

// File: rtl/stride_pf.sv
module stride_pf #(
  parameter int ENTRIES    = 16,
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int PC_LSB     = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_valid_i,
  output logic          acc_ready_o,
  input  logic [AW-1:0] acc_pc_i,
  input  logic [AW-1:0] acc_addr_i,
  output logic          probe_valid_o,
  output logic [AW-1:0] probe_addr_o,
  input  logic          probe_hit_i,
  output logic          pf_valid_o,
  output logic [AW-1:0] pf_addr_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = AW - PC_LSB - IDX_W;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] pc_tag, rd_tag, wr_tag;
  logic [AW-1:0]    rd_prev, rd_stride, wr_prev, wr_stride;
  logic [1:0]       rd_state, wr_state;
  logic             take, cand_valid;
  logic [AW-1:0]    cand_line;
  logic             unused_pc_lsb;

  assign acc_ready_o   = 1'b1;
  assign take          = acc_valid_i && acc_ready_o;
  assign idx           = acc_pc_i[PC_LSB +: IDX_W];
  assign pc_tag        = acc_pc_i[AW-1 -: TAG_W];
  assign unused_pc_lsb = ^acc_pc_i[PC_LSB-1:0];

  spf_table #(.ENTRIES(ENTRIES), .AW(AW), .TAG_W(TAG_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (idx),
    .rd_tag_o    (rd_tag),
    .rd_prev_o   (rd_prev),
    .rd_stride_o (rd_stride),
    .rd_state_o  (rd_state),
    .wr_en_i     (take),
    .wr_idx_i    (idx),
    .wr_tag_i    (wr_tag),
    .wr_prev_i   (wr_prev),
    .wr_stride_i (wr_stride),
    .wr_state_i  (wr_state)
  );

  spf_update #(.AW(AW), .TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES)) u_update (
    .pc_tag_i     (pc_tag),
    .addr_i       (acc_addr_i),
    .ent_tag_i    (rd_tag),
    .ent_prev_i   (rd_prev),
    .ent_stride_i (rd_stride),
    .ent_state_i  (rd_state),
    .new_tag_o    (wr_tag),
    .new_prev_o   (wr_prev),
    .new_stride_o (wr_stride),
    .new_state_o  (wr_state),
    .cand_valid_o (cand_valid),
    .cand_line_o  (cand_line)
  );

  spf_issue #(.AW(AW)) u_issue (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cand_valid_i  (take && cand_valid),
    .cand_line_i   (cand_line),
    .probe_valid_o (probe_valid_o),
    .probe_addr_o  (probe_addr_o),
    .probe_hit_i   (probe_hit_i),
    .pf_valid_o    (pf_valid_o),
    .pf_addr_o     (pf_addr_o)
  );
endmodule

// File: rtl/stride_pf_checker.sv
module stride_pf_checker #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          acc_valid_i,
  input logic          acc_ready_o,
  input logic [AW-1:0] acc_addr_i,
  input logic          probe_valid_o,
  input logic [AW-1:0] probe_addr_o,
  input logic          probe_hit_i,
  input logic          pf_valid_o,
  input logic [AW-1:0] pf_addr_o
);
  localparam logic [AW-1:0] MASK = ~AW'(LINE_BYTES - 1);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_quiet_in_reset_r1: assert (!probe_valid_o && !pf_valid_o);
    end
  end

  p_probe_follows_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_valid_o |-> $past(acc_valid_i && acc_ready_o));

  p_probe_aligned_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_valid_o |-> (probe_addr_o & ~MASK) == '0);

  p_other_line_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_valid_o |-> probe_addr_o != ($past(acc_addr_i) & MASK));

  p_miss_prefetches_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (probe_valid_o && !probe_hit_i) |=> (pf_valid_o && pf_addr_o == $past(probe_addr_o)));

  p_pf_needs_miss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> $past(probe_valid_o && !probe_hit_i));
endmodule

bind stride_pf stride_pf_checker #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .acc_valid_i   (acc_valid_i),
  .acc_ready_o   (acc_ready_o),
  .acc_addr_i    (acc_addr_i),
  .probe_valid_o (probe_valid_o),
  .probe_addr_o  (probe_addr_o),
  .probe_hit_i   (probe_hit_i),
  .pf_valid_o    (pf_valid_o),
  .pf_addr_o     (pf_addr_o)
);

// File: tb/tb_stride_pf.sv
module tb_stride_pf;
  localparam int AW = 32;
  localparam int ENTRIES = 16;
  localparam int LINE_BYTES = 32;
  localparam logic [31:0] MASK = ~32'(LINE_BYTES - 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic acc_valid_i = 1'b0;
  logic acc_ready_o;
  logic [31:0] acc_pc_i = '0, acc_addr_i = '0;
  logic probe_valid_o, probe_hit_i, pf_valid_o;
  logic [31:0] probe_addr_o, pf_addr_o;
  logic present_en = 1'b0;
  logic [31:0] present_line = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign probe_hit_i = present_en && probe_valid_o && (probe_addr_o == present_line);

  stride_pf #(.ENTRIES(ENTRIES), .AW(AW), .LINE_BYTES(LINE_BYTES), .PC_LSB(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .acc_valid_i(acc_valid_i), .acc_ready_o(acc_ready_o),
    .acc_pc_i(acc_pc_i), .acc_addr_i(acc_addr_i),
    .probe_valid_o(probe_valid_o), .probe_addr_o(probe_addr_o), .probe_hit_i(probe_hit_i),
    .pf_valid_o(pf_valid_o), .pf_addr_o(pf_addr_o)
  );

  // arithmetic model of the table
  logic [25:0] m_tag [ENTRIES];
  logic [31:0] m_prev [ENTRIES];
  logic [31:0] m_stride [ENTRIES];
  logic [1:0]  m_state [ENTRIES];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_step(input logic [31:0] pc, input logic [31:0] a,
                            output logic ev, output logic [31:0] el);
    int i = int'(pc[5:2]);
    logic [25:0] t = pc[31:6];
    logic [31:0] s;
    logic [1:0] st;
    if (m_tag[i] != t || m_tag[i] == '0) begin            // R3 allocate
      m_tag[i] = t; m_stride[i] = 0; m_state[i] = 2'd0;
    end else begin
      s = a - m_prev[i];                                  // R4
      st = m_state[i];
      if (s == m_stride[i]) begin                         // R5
        m_state[i] = (st == 2'd3) ? 2'd1 : 2'd2;
      end else begin                                      // R6
        case (st)
          2'd0: m_state[i] = 2'd1;
          2'd1: m_state[i] = 2'd3;
          2'd2: m_state[i] = 2'd0;
          default: m_state[i] = 2'd3;
        endcase
        if (st != 2'd2) m_stride[i] = s;
      end
    end
    m_prev[i] = a;
    el = (a + m_stride[i]) & MASK;                        // R7
    ev = (m_state[i] != 2'd3) && (el != (a & MASK));      // R8
  endtask

  task automatic access(input logic [31:0] pc, input logic [31:0] a,
                        output logic pv, output logic [31:0] pl,
                        output logic fv, output logic [31:0] fl);
    @(negedge clk);
    acc_valid_i = 1'b1; acc_pc_i = pc; acc_addr_i = a;
    @(negedge clk);
    acc_valid_i = 1'b0;
    pv = probe_valid_o; pl = probe_addr_o;
    @(negedge clk);
    fv = pf_valid_o; fl = pf_addr_o;
  endtask

  // directed access: expected probe/prefetch given literally
  task automatic dir(input logic [31:0] pc, input logic [31:0] a, input logic exp_v,
                     input logic [31:0] exp_l, input string req);
    logic pv, fv, mv, hit;
    logic [31:0] pl, fl, ml;
    model_step(pc, a, mv, ml);
    access(pc, a, pv, pl, fv, fl);
    hit = present_en && exp_l == present_line;
    check(pv == exp_v && (!exp_v || pl == exp_l), {req, " probe"}, pl, exp_l);
    check(fv == (exp_v && !hit) && (!fv || fl == exp_l), {req, " prefetch"}, {31'd0, fv}, {31'd0, exp_v && !hit});
  endtask

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin
      m_tag[i] = '0; m_prev[i] = '0; m_stride[i] = '0; m_state[i] = '0;
    end
    repeat (3) @(negedge clk);
    check(!probe_valid_o && !pf_valid_o, "R1 outputs in reset", {31'd0, pf_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(acc_ready_o && !probe_valid_o && !pf_valid_o, "R1 after reset", {31'd0, acc_ready_o}, 1);

    // PC 0x1000: idx 0, tag 0x40
    dir(32'h1000, 32'h2000, 0, 0, "R1 R3 first access");
    dir(32'h1000, 32'h2040, 1, 32'h2080, "R6 init->trans");
    dir(32'h1000, 32'h2080, 1, 32'h20C0, "R5 trans->steady");
    dir(32'h1000, 32'h20C0, 1, 32'h2100, "R5 steady stays");
    dir(32'h1000, 32'h2000, 1, 32'h2040, "R6 steady->init keeps stride");
    dir(32'h1000, 32'h2040, 1, 32'h2080, "R5 init->steady");
    dir(32'h1000, 32'h2100, 1, 32'h2140, "R6 steady->init");
    dir(32'h1000, 32'h2120, 1, 32'h2140, "R6 init->trans new stride");
    dir(32'h1000, 32'h2200, 0, 0, "R6 trans->nopred");
    dir(32'h1000, 32'h2300, 0, 0, "R6 nopred stays");
    dir(32'h1000, 32'h2400, 1, 32'h2500, "R5 nopred->trans");
    // negative stride, PC 0x1004 idx 1
    dir(32'h1004, 32'h5000, 0, 0, "R3 alloc");
    dir(32'h1004, 32'h4F00, 1, 32'h4E00, "R4 negative stride");
    dir(32'h1004, 32'h4E00, 1, 32'h4D00, "R4 negative steady");
    // small strides within one line, PC 0x1008 idx 2
    dir(32'h1008, 32'h3000, 0, 0, "R3 zero stride no probe");
    dir(32'h1008, 32'h3004, 0, 0, "R8 same line trans");
    dir(32'h1008, 32'h3008, 0, 0, "R8 same line steady");
    present_en = 1'b1; present_line = 32'h3020;
    dir(32'h1008, 32'h301C, 1, 32'h3020, "R9 present line filtered");
    present_en = 1'b0;
    // alias: 0x1040 shares idx 0 with 0x1000
    dir(32'h1040, 32'h7000, 0, 0, "R2 alias evicts");
    dir(32'h1000, 32'h2500, 0, 0, "R2 evicted pattern lost");
    dir(32'h1000, 32'h2560, 1, 32'h25C0, "R2 relearn");

    // R10 back-to-back same PC
    begin
      logic v1, v2; logic [31:0] l1, l2;
      model_step(32'h100C, 32'h8000, v1, l1);
      model_step(32'h100C, 32'h8080, v2, l2);
      @(negedge clk);
      acc_valid_i = 1; acc_pc_i = 32'h100C; acc_addr_i = 32'h8000;
      @(negedge clk);
      acc_addr_i = 32'h8080;
      check(!probe_valid_o, "R10 first of pair no probe", {31'd0, probe_valid_o}, 0);
      @(negedge clk);
      acc_valid_i = 0;
      check(probe_valid_o == v2 && probe_addr_o == l2, "R10 second sees first", probe_addr_o, l2);
      @(negedge clk);
      check(pf_valid_o && pf_addr_o == 32'h8100, "R10 prefetch", pf_addr_o, 32'h8100);
    end

    // pseudo-random sweep: 4 PCs aliasing on 2 slots
    begin
      logic [31:0] lfsr = 32'h1ACE_B00C;
      logic [31:0] cur [4];
      logic [31:0] strides [6];
      strides[0] = 32'h20; strides[1] = 32'h20; strides[2] = -32'sd64;
      strides[3] = 32'h8; strides[4] = 32'h100; strides[5] = 32'h0;
      for (int k = 0; k < 4; k++) cur[k] = 32'h1_0000 * (k + 1);
      for (int n = 0; n < 3000; n++) begin
        logic pv, fv, ev; logic [31:0] pl, fl, el, pc;
        int p;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        p = int'(lfsr[1:0]);
        pc = 32'h2000 + {28'd0, lfsr[0], 2'b0} + {26'd0, lfsr[1], 6'd0};
        if (lfsr[7:5] != 3'd7) cur[p] = cur[p] + strides[int'(lfsr[10:8]) % 6];
        else cur[p] = cur[p] + {20'd0, lfsr[23:12]};
        model_step(pc, cur[p], ev, el);
        present_en = lfsr[27] & lfsr[28];
        present_line = el;
        access(pc, cur[p], pv, pl, fv, fl);
        check(pv == ev && (!ev || pl == el), "R5 R6 R7 sweep probe", pl, el);
        check(fv == (ev && !present_en) && (!fv || fl == el), "R9 sweep prefetch", fl, el);
      end
      present_en = 1'b0;
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule